// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog Timer

This block is a per-core watchdog that raises alarms in steps when software stops servicing it. A single configuration write gives it a 16-bit length and a 2-bit mode. The length is placed in the upper bits of a wider down-counter. That counter steps once per prescaler wrap, so one period can run to roughly 2^32 clocks with the default widths. Software sends a one-cycle poke to show it is still alive.

When a whole period passes with no poke, the block enters the interrupt stage. A second silent period moves it to the NMI stage, and a third moves it to the soft-reset-request stage. The mode sets how far the escalation may go: 0 turns the block off, 1 stops at the interrupt, 2 stops at the NMI and 3 allows all three stages. A 2-bit stage code is visible on a status output. The stage code has bit 1 set from the NMI stage on, so an NMI handler can tell a watchdog NMI from any other NMI.

Top module: `wdg_escalate`

## Requirements
- R1: After a configuration write or a poke, the first stage is entered after exactly (L * 2^LOW_W + 1) * 2^PRE_W clock edges, where L is the programmed length. The counter is seeded with L in its upper LEN_W bits and zeros below, it steps once per 2^PRE_W clocks, and the stage advances at the step that finds it already at zero.
- R2: When the first period expires, the stage code becomes 1 and irq_o goes high.
- R3: After one more full period with no poke, the stage code becomes 2 and nmi_o goes high. Status bit 1 (stage_o[1]) is set from this stage onward.
- R4: After a third full period, the stage code becomes 3 and soft_rst_o goes high. The block then holds stage 3.
- R5: All alarm outputs are levels. Once an output is raised, it stays high (together with every earlier stage's output) until a poke, a configuration write or reset.
- R6: Mode 1 stops the escalation at stage 1 and mode 2 stops it at stage 2. The block then holds that stage indefinitely, and the later outputs stay low.
- R7: Mode 0 disables the block. Writing length 0 with mode 0 clears every output, and nothing escalates afterwards. A poke while the block is disabled changes no output.
- R8: A poke returns the stage code to 0, drops every alarm output on the next edge and restarts a full period from the stored length.
- R9: A configuration write clears the stage on the next edge and starts the period with the newly written length, even if the block is in the middle of a period.
- R10: Length 0 gives the shortest period, exactly 2^PRE_W clocks per stage.
- R11: While reset is asserted, the stage code is 0, all outputs are low and the mode is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | One-cycle configuration write strobe |
| cfg_len_i | input | LEN_W | Length; becomes the upper bits of the down-counter |
| cfg_mode_i | input | 2 | Escalation limit: 0 off, 1 interrupt, 2 NMI, 3 soft reset |
| poke_i | input | 1 | One-cycle keep-alive strobe |
| irq_o | output | 1 | Interrupt stage reached (level) |
| nmi_o | output | 1 | NMI stage reached (level) |
| soft_rst_o | output | 1 | Soft-reset request stage reached (level) |
| stage_o | output | 2 | Current stage code: 0 counting, 1 interrupt, 2 NMI, 3 reset |

## Verification
The hardest case to reach is the exact edge at which each stage begins, and that edge has to be checked again after a poke or a rewrite lands in the middle of a period. A full period at the default widths is far too long to simulate, so the bench instantiates the block with narrow counter and prescaler widths. It then predicts every transition edge from the R1 formula. Each directed scenario samples one cycle before and one cycle at each predicted edge, with pokes and rewrites placed mid-period, so a period that is off by even a single clock is caught.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {
      STG_COUNT = 2'd0,
      STG_IRQ   = 2'd1,
      STG_NMI   = 2'd2,
      STG_RESET = 2'd3
   } wdg_stage_e;

   localparam logic [1:0] MODE_OFF = 2'd0;
   localparam logic [1:0] MODE_IRQ = 2'd1;
   localparam logic [1:0] MODE_NMI = 2'd2;
   localparam logic [1:0] MODE_ALL = 2'd3;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic en_i,
   output logic tick_o
);
   generate
      if (PRE_W == 0) begin : g_direct
         // every enabled cycle is a step
         assign tick_o = en_i;
      end else begin : g_count
         localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      pre_q <= '0;
            else if (clear_i) pre_q <= '0;
            else if (en_i)    pre_q <= pre_q + 1'b1;
         end
         assign tick_o = en_i && (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdg_decrementer.sv
module wdg_decrementer #(
   parameter int LEN_W = 16,
   parameter int LOW_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             run_i,
   input  logic             tick_i,
   output logic             expire_o
);
   localparam int CNT_W = LEN_W + LOW_W;

   logic [CNT_W-1:0] seed;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (LOW_W > 0) begin : g_pad
         assign seed = {len_i, {LOW_W{1'b0}}};
      end else begin : g_nopad
         assign seed = len_i;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= seed;
      end else if (run_i && tick_i) begin
         if (cnt_q == '0) cnt_q <= seed;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = run_i && tick_i && (cnt_q == '0);
endmodule

// File: rtl/wdg_stage_fsm.sv
module wdg_stage_fsm
   import wdg_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       clear_i,
   input  logic       expire_i,
   input  logic [1:0] cap_i,
   output wdg_stage_e stage_o
);
   wdg_stage_e stage_q;
   wdg_stage_e stage_d;

   always_comb begin
      stage_d = stage_q;
      if (clear_i) begin
         stage_d = STG_COUNT;
      end else if (expire_i && (stage_q < wdg_stage_e'(cap_i))) begin
         case (stage_q)
            STG_COUNT: stage_d = STG_IRQ;
            STG_IRQ:   stage_d = STG_NMI;
            STG_NMI:   stage_d = STG_RESET;
            default:   stage_d = STG_RESET;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= STG_COUNT;
      else         stage_q <= stage_d;
   end

   assign stage_o = stage_q;
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
   import wdg_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int LOW_W = 8,
   parameter int PRE_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_we_i,
   input  logic [LEN_W-1:0] cfg_len_i,
   input  logic [1:0]       cfg_mode_i,
   input  logic             poke_i,
   output logic             irq_o,
   output logic             nmi_o,
   output logic             soft_rst_o,
   output logic [1:0]       stage_o
);
   generate
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
      if (LOW_W < 0 || PRE_W < 0) begin : g_bad_scale
         $error("LOW_W and PRE_W must not be negative");
      end
      if (LEN_W + LOW_W > 64) begin : g_bad_cnt
         $error("counter wider than 64 bits");
      end
   endgenerate

   logic [LEN_W-1:0] len_q;
   logic [1:0]       mode_q;
   logic             clear;
   logic             enabled;
   logic             run;
   logic             tick;
   logic             expire;
   logic [LEN_W-1:0] load_len;
   wdg_stage_e       stage;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         len_q  <= '0;
         mode_q <= MODE_OFF;
      end else if (cfg_we_i) begin
         len_q  <= cfg_len_i;
         mode_q <= cfg_mode_i;
      end
   end

   assign clear    = cfg_we_i || poke_i;
   assign enabled  = (mode_q != MODE_OFF);
   assign run      = enabled && (stage < wdg_stage_e'(mode_q));
   assign load_len = cfg_we_i ? cfg_len_i : len_q;

   wdg_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .en_i    (run),
      .tick_o  (tick)
   );

   wdg_decrementer #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_dec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (clear),
      .len_i    (load_len),
      .run_i    (run),
      .tick_i   (tick),
      .expire_o (expire)
   );

   wdg_stage_fsm u_fsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (clear),
      .expire_i (expire),
      .cap_i    (mode_q),
      .stage_o  (stage)
   );

   assign stage_o    = stage;
   assign irq_o      = (stage != STG_COUNT);
   assign nmi_o      = (stage == STG_NMI) || (stage == STG_RESET);
   assign soft_rst_o = (stage == STG_RESET);
endmodule

// File: rtl/wdg_escalate_chk.sv
module wdg_escalate_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       cfg_we_i,
   input logic       poke_i,
   input logic       irq_o,
   input logic       nmi_o,
   input logic       soft_rst_o,
   input logic [1:0] stage_o,
   input logic [1:0] mode_q
);
   AST_STAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(stage_o) |-> (stage_o == 2'($past(stage_o) + 2'd1)) || (stage_o == 2'd0)); // R4

   AST_MODE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_o <= mode_q); // R6

   AST_POKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      poke_i |=> (stage_o == 2'd0) && !irq_o); // R8

   AST_CFG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_i |=> (stage_o == 2'd0) && !nmi_o); // R9

   AST_RESET_AFTER_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(soft_rst_o) |-> $past(nmi_o)); // R3

   AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !cfg_we_i && !poke_i) |=> irq_o); // R5

   AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == 2'd0) |-> !irq_o && !soft_rst_o); // R7
endmodule

bind wdg_escalate wdg_escalate_chk chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cfg_we_i   (cfg_we_i),
   .poke_i     (poke_i),
   .irq_o      (irq_o),
   .nmi_o      (nmi_o),
   .soft_rst_o (soft_rst_o),
   .stage_o    (stage_o),
   .mode_q     (mode_q)
);

// File: tb/wdg_escalate_tb_top.sv
module wdg_escalate_tb_top;
   localparam int LEN_W = 4;
   localparam int LOW_W = 2;
   localparam int PRE_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic [1:0]       cfg_mode = 2'd0;
   logic             poke = 1'b0;
   logic             irq, nmi, srst;
   logic [1:0]       stage;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdg_escalate #(.LEN_W(LEN_W), .LOW_W(LOW_W), .PRE_W(PRE_W)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cfg_we_i   (cfg_we),
      .cfg_len_i  (cfg_len),
      .cfg_mode_i (cfg_mode),
      .poke_i     (poke),
      .irq_o      (irq),
      .nmi_o      (nmi),
      .soft_rst_o (srst),
      .stage_o    (stage)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic int period(int len);
      return (len * (1 << LOW_W) + 1) * (1 << PRE_W);
   endfunction

   // expected word: {irq, nmi, soft_rst, stage[1:0]}
   task automatic expect_out(string tag, logic [4:0] exp);
      logic [4:0] act;
      act = {irq, nmi, srst, stage};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg_write(int len, logic [1:0] mode);
      @(negedge clk);
      cfg_len = LEN_W'(len);
      cfg_mode = mode;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_poke();
      @(negedge clk);
      poke = 1'b1;
      @(negedge clk);
      poke = 1'b0;
   endtask

   task automatic t_reset();
      expect_out("R11 in reset", 5'b000_00);
      step(2);
      rst_n = 1'b1;
      step(3);
      expect_out("R11 after reset", 5'b000_00);
   endtask

   task automatic t_full_escalation();
      int t;
      t = period(1);
      cfg_write(1, 2'd3);
      step(t - 1);
      expect_out("R1 before first expiry", 5'b000_00);
      step(1);
      expect_out("R2 interrupt stage", 5'b100_01);
      step(t - 1);
      expect_out("R5 interrupt held", 5'b100_01);
      step(1);
      expect_out("R3 NMI stage status bit1", 5'b110_10);
      step(t - 1);
      expect_out("R3 NMI held", 5'b110_10);
      step(1);
      expect_out("R4 soft reset stage", 5'b111_11);
      step(3 * t);
      expect_out("R4 R5 reset stage held", 5'b111_11);
      do_poke();
      expect_out("R8 poke clears from reset stage", 5'b000_00);
   endtask

   task automatic t_poke_mid();
      int t;
      t = period(2);
      cfg_write(2, 2'd3);
      step(t / 2);
      do_poke();
      step(t - 1);
      expect_out("R8 poke restarts full period", 5'b000_00);
      step(1);
      expect_out("R8 expiry after poke", 5'b100_01);
      do_poke();
      expect_out("R8 poke drops interrupt", 5'b000_00);
      step(t - 1);
      expect_out("R8 second restart pending", 5'b000_00);
      step(1);
      expect_out("R8 second restart expiry", 5'b100_01);
   endtask

   task automatic t_modes();
      int t;
      t = period(0);
      cfg_write(0, 2'd1);
      step(t - 1);
      expect_out("R10 zero length before", 5'b000_00);
      step(1);
      expect_out("R10 zero length expiry", 5'b100_01);
      step(6 * t);
      expect_out("R6 mode1 holds interrupt", 5'b100_01);
      cfg_write(1, 2'd2);
      t = period(1);
      step(2 * t);
      expect_out("R6 mode2 NMI", 5'b110_10);
      step(3 * t);
      expect_out("R6 mode2 holds NMI", 5'b110_10);
   endtask

   task automatic t_disable();
      int t;
      t = period(0);
      cfg_write(0, 2'd3);
      step(t);
      expect_out("R7 setup interrupt", 5'b100_01);
      cfg_write(0, 2'd0);
      expect_out("R7 disable clears", 5'b000_00);
      step(20 * t);
      expect_out("R7 disabled no escalation", 5'b000_00);
      do_poke();
      step(5 * t);
      expect_out("R7 poke while off", 5'b000_00);
   endtask

   task automatic t_rewrite();
      int t;
      cfg_write(1, 2'd3);
      step(10);
      cfg_write(2, 2'd3);
      t = period(2);
      step(t - 1);
      expect_out("R9 new length pending", 5'b000_00);
      step(1);
      expect_out("R9 new length expiry", 5'b100_01);
      cfg_write(0, 2'd3);
      expect_out("R9 write clears stage", 5'b000_00);
   endtask

   task automatic t_async_reset();
      cfg_write(0, 2'd3);
      step(3 * period(0));
      expect_out("R4 short escalation", 5'b111_11);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      expect_out("R11 reset clears", 5'b000_00);
      step(2);
      rst_n = 1'b1;
      step(10);
      expect_out("R11 off after reset", 5'b000_00);
   endtask

   initial begin
      t_reset();
      t_full_escalation();
      t_poke_mid();
      t_modes();
      t_disable();
      t_rewrite();
      t_async_reset();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule